// File: doc/BRIEF.md
# Bus Error Capture Register with Freeze-on-First-Error

This block keeps one node's record of bus faults. The bus interface logic reports errors as single-cycle pulses on a 32-bit event vector, with one lane for each error class. Each pulse sets the matching sticky bit in a status word. Software reads the status word and clears it through a small register port, which uses write-one-to-clear. A companion configuration word lives in the same block. It holds a freeze control, which captures only the first failure for diagnosis, two interrupt suppressions for correctable data errors, and two gates that switch off the bank-lock timeout check and the data timeout check.

When the freeze control is on, an event that sets any status bit outside the four data-syndrome indicator lanes (20 to 23) locks the status word. While the word is locked, new events are dropped and only software clears change it. The lock ends when the status word becomes all zero or when software turns the freeze control off. An interrupt line stays high while any status bit that is not suppressed is set.

Top module: `bus_err_capture`

## Requirements
- R1: A pulse on `evt_i[i]` while the word is unlocked sets status bit i at the next clock edge. The bit then stays set until software clears it.
- R2: `rd_sel_i` = 0 returns the status word on `rd_data_o`, and `rd_sel_i` = 1 returns the configuration word. Configuration bits 0, 1, 2, 3 and 31 are writable and read back as written. All other configuration bits read as 0.
- R3: A write with `wr_sel_i` = 0 clears every status bit whose `wr_data_i` bit is 1 and leaves the other status bits unchanged.
- R4: If an event and a clear hit the same status bit in the same cycle while the word is unlocked, the bit ends up set.
- R5: `irq_o` is high exactly while some status bit is set and not suppressed. Configuration bit 0 suppresses status bit 17 (correctable write data). Configuration bit 1 suppresses status bits 18 and 19 (correctable read data).
- R6: While configuration bit 2 is set, an event never sets status bit 3 (bank-lock timeout). While configuration bit 3 is set, an event never sets status bit 31 (data timeout). Other bits are not affected by these gates.
- R7: Events confined to the syndrome lanes 20 to 23 never lock the word.
- R8: With configuration bit 31 set, a captured event on any bit outside 20 to 23 raises `locked_o` at the same edge that captures it. While the word is locked, events are ignored and clears still apply.
- R9: A locked word unlocks at the edge where its status becomes all zero. Partial clears keep it locked.
- R10: Clearing configuration bit 31 releases the lock one cycle after the write takes effect. Events are then captured again.
- R11: Synchronous reset sets the status word, the configuration word, `locked_o` and `irq_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Error event pulses, one lane per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = status (write-one-to-clear), 1 = configuration |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 = status, 1 = configuration |
| rd_data_o | output | 32 | Selected register contents (combinational) |
| irq_o | output | 1 | Unsuppressed error pending |
| locked_o | output | 1 | Status word frozen by the first-error lock |

## Verification
A status bit that is wrongly sticky or wrongly cleared shows on the status read one cycle after the event or clear that should have set or cleared it. The same fault shows on `irq_o` in the same cycle as the bad bit. If the lock flag is wrong, it is exposed by the next event. A wrongly set flag means that event is missing from the status read, and a wrongly clear flag means the event shows up when it should have been dropped. If a syndrome-only event locks the word, the one event that follows it is lost. A broken gate or suppression shows at once as a forbidden bit 3 or bit 31, or as an `irq_o` level that does not match the configuration.

// File: rtl/berr_pkg.sv
package berr_pkg;

    localparam int REG_W        = 32;
    localparam int SYND_LO      = 20;
    localparam int SYND_HI      = 23;
    localparam int ST_LKTO      = 3;
    localparam int ST_DTO       = 31;
    localparam int ST_CWD       = 17;
    localparam int ST_CRD_LO    = 18;
    localparam int ST_CRD_HI    = 19;
    localparam int CF_CWD_QUIET = 0;
    localparam int CF_CRD_QUIET = 1;
    localparam int CF_LKTO_OFF  = 2;
    localparam int CF_DTO_OFF   = 3;
    localparam int CF_FREEZE    = 31;

    typedef logic [REG_W-1:0] word_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CONFIG = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic freeze;
        logic dto_off;
        logic lkto_off;
        logic crd_quiet;
        logic cwd_quiet;
    } cfg_t;

    function automatic word_t synd_lanes();
        word_t m = '0;
        for (int b = SYND_LO; b <= SYND_HI; b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic word_t cfg_to_word(cfg_t c);
        word_t w = '0;
        w[CF_CWD_QUIET] = c.cwd_quiet;
        w[CF_CRD_QUIET] = c.crd_quiet;
        w[CF_LKTO_OFF]  = c.lkto_off;
        w[CF_DTO_OFF]   = c.dto_off;
        w[CF_FREEZE]    = c.freeze;
        return w;
    endfunction

    // lanes that an event may set under this configuration
    function automatic word_t event_gate(cfg_t c);
        word_t g = '1;
        g[ST_LKTO] = ~c.lkto_off;
        g[ST_DTO]  = ~c.dto_off;
        return g;
    endfunction

    // lanes that may drive the interrupt under this configuration
    function automatic word_t irq_gate(cfg_t c);
        word_t g = '1;
        g[ST_CWD] = ~c.cwd_quiet;
        for (int b = ST_CRD_LO; b <= ST_CRD_HI; b++) g[b] = ~c.crd_quiet;
        return g;
    endfunction

endpackage

// File: rtl/berr_cfg_reg.sv
module berr_cfg_reg
    import berr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cfg_t wval,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= '0;
        else if (we) cfg_q <= wval;
    end
endmodule

// File: rtl/berr_status_reg.sv
module berr_status_reg
    import berr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  word_t set_v,
    input  word_t clr_v,
    output word_t nxt_o,
    output word_t q_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        always_comb begin
            if (set_v[i] && !hold) nxt_o[i] = 1'b1;
            else if (clr_v[i])     nxt_o[i] = 1'b0;
            else                   nxt_o[i] = q_o[i];
        end

        always_ff @(posedge clk) begin
            if (rst) q_o[i] <= 1'b0;
            else     q_o[i] <= nxt_o[i];
        end
    end
endmodule

// File: rtl/berr_lock_ctl.sv
module berr_lock_ctl
    import berr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  freeze,
    input  word_t trig_v,
    input  word_t status_nxt,
    output logic  locked_q
);
    localparam word_t NON_SYND = ~synd_lanes();

    logic locked_nxt;

    always_comb begin
        if (!freeze)       locked_nxt = 1'b0;
        else if (locked_q) locked_nxt = |status_nxt;
        else               locked_nxt = |(trig_v & NON_SYND);
    end

    always_ff @(posedge clk) begin
        if (rst) locked_q <= 1'b0;
        else     locked_q <= locked_nxt;
    end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import berr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] evt_i,
    input  logic        wr_en_i,
    input  logic        wr_sel_i,
    input  logic [31:0] wr_data_i,
    input  logic        rd_sel_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o,
    output logic        locked_o
);
    cfg_t  cfg_q;
    cfg_t  cfg_wval;
    word_t cfg_word;
    word_t status_q;
    word_t status_nxt;
    word_t trig_v;
    word_t clr_v;
    logic  cfg_we;
    logic  locked;

    assign cfg_we   = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CONFIG);
    assign cfg_wval = '{freeze:    wr_data_i[CF_FREEZE],
                        dto_off:   wr_data_i[CF_DTO_OFF],
                        lkto_off:  wr_data_i[CF_LKTO_OFF],
                        crd_quiet: wr_data_i[CF_CRD_QUIET],
                        cwd_quiet: wr_data_i[CF_CWD_QUIET]};

    berr_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wval  (cfg_wval),
        .cfg_q (cfg_q)
    );

    assign trig_v = evt_i & event_gate(cfg_q);
    assign clr_v  = (wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS)) ? wr_data_i : '0;

    berr_status_reg u_status (
        .clk   (clk),
        .rst   (rst),
        .hold  (locked),
        .set_v (trig_v),
        .clr_v (clr_v),
        .nxt_o (status_nxt),
        .q_o   (status_q)
    );

    berr_lock_ctl u_lock (
        .clk        (clk),
        .rst        (rst),
        .freeze     (cfg_q.freeze),
        .trig_v     (trig_v),
        .status_nxt (status_nxt),
        .locked_q   (locked)
    );

    assign cfg_word  = cfg_to_word(cfg_q);
    assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_CONFIG) ? cfg_word : status_q;
    assign irq_o     = |(status_q & irq_gate(cfg_q));
    assign locked_o  = locked;
endmodule

// File: rtl/berr_chk.sv
module berr_chk
    import berr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] evt_i,
    input logic        wr_en_i,
    input logic        wr_sel_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] status_q,
    input logic [31:0] cfg_word,
    input logic        locked,
    input logic        irq_o
);
    localparam word_t NON_SYND = ~synd_lanes();

    logic st_wr;
    assign st_wr = wr_en_i && (wr_sel_i == 1'b0);

    // R8
    frozen_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !st_wr) |=> $stable(status_q));

    // R6
    lkto_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_word[CF_LKTO_OFF] |=> !$rose(status_q[ST_LKTO]));

    // R6
    dto_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_word[CF_DTO_OFF] |=> !$rose(status_q[ST_DTO]));

    // R7
    synd_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && ((evt_i & NON_SYND) == '0)) |=> !locked);

    // R10
    freeze_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_word[CF_FREEZE] |=> !locked);

    // R5
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq_o);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (st_wr && ((evt_i & wr_data_i) == '0)) |=> ((status_q & $past(wr_data_i)) == '0));
endmodule

bind bus_err_capture berr_chk u_berr_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .status_q  (status_q),
    .cfg_word  (cfg_word),
    .locked    (locked),
    .irq_o     (irq_o)
);

// File: tb/tb_bus_err_capture.sv
`timescale 1ns/1ps
module tb_bus_err_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    logic        locked;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bus_err_capture dut (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .locked_o  (locked)
    );

    task automatic tick();
        @(posedge clk);
        #2;
        evt   = '0;
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt = e;
        tick();
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic sel, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R11 reset state
        chk_reg("R11 status", 1'b0, 32'h0);
        chk_reg("R11 config", 1'b1, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 locked", {31'b0, locked}, 32'h0);

        // R1 / R3 sweep over every lane
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            chk_reg($sformatf("R1 lane %0d set", i), 1'b0, 32'h1 << i);
            chk($sformatf("R5 lane %0d irq", i), {31'b0, irq}, 32'h1);
            tick();
            chk_reg($sformatf("R1 lane %0d held", i), 1'b0, 32'h1 << i);
            wr(1'b0, 32'h1 << i);
            chk_reg($sformatf("R3 lane %0d clear", i), 1'b0, 32'h0);
        end

        // R3 partial clear
        pulse(32'h0000_0F0F);
        wr(1'b0, 32'h0000_0303);
        chk_reg("R3 partial", 1'b0, 32'h0000_0C0C);
        wr(1'b0, 32'hFFFF_FFFF);

        // R4 event beats clear
        evt = 32'h0000_0020; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0020;
        tick();
        chk_reg("R4 event wins", 1'b0, 32'h0000_0020);
        wr(1'b0, 32'hFFFF_FFFF);

        // R2 configuration readback
        wr(1'b1, 32'hFFFF_FFFF);
        chk_reg("R2 cfg all ones", 1'b1, 32'h8000_000F);
        wr(1'b1, 32'h0000_0005);
        chk_reg("R2 cfg pattern", 1'b1, 32'h0000_0005);
        wr(1'b1, 32'h0);
        chk_reg("R2 cfg zero", 1'b1, 32'h0);

        // R6 timeout gates, all four combinations
        for (int c = 0; c < 4; c++) begin
            logic [31:0] exp;
            wr(1'b1, 32'(c) << 2);
            pulse(32'h8000_0018);
            exp = 32'h0000_0010 | (c[0] ? 32'h0 : 32'h8) | (c[1] ? 32'h0 : 32'h8000_0000);
            chk_reg($sformatf("R6 gate %0d", c), 1'b0, exp);
            wr(1'b0, 32'hFFFF_FFFF);
        end

        // R5 interrupt suppression over data-error lanes
        for (int c = 0; c < 4; c++) begin
            wr(1'b1, 32'(c));
            for (int b = 16; b < 20; b++) begin
                logic quiet;
                quiet = (b == 17 && c[0]) || ((b == 18 || b == 19) && c[1]);
                pulse(32'h1 << b);
                chk_reg($sformatf("R5 lane %0d cfg %0d status", b, c), 1'b0, 32'h1 << b);
                chk($sformatf("R5 lane %0d cfg %0d irq", b, c), {31'b0, irq}, {31'b0, !quiet});
                wr(1'b0, 32'hFFFF_FFFF);
            end
        end
        wr(1'b1, 32'h0);

        // R7 syndrome-only events do not lock
        wr(1'b1, 32'h8000_0000);
        pulse(32'h00F0_0000);
        chk_reg("R7 synd captured", 1'b0, 32'h00F0_0000);
        chk("R7 not locked", {31'b0, locked}, 32'h0);

        // R8 lock on first real error, later events ignored
        pulse(32'h0000_0002);
        chk_reg("R8 first error", 1'b0, 32'h00F0_0002);
        chk("R8 locked", {31'b0, locked}, 32'h1);
        pulse(32'h0000_0020);
        chk_reg("R8 event ignored", 1'b0, 32'h00F0_0002);

        // R9 partial clear keeps lock, full clear releases
        wr(1'b0, 32'h0000_0002);
        chk_reg("R9 partial clear", 1'b0, 32'h00F0_0000);
        chk("R9 still locked", {31'b0, locked}, 32'h1);
        pulse(32'h0000_0040);
        chk_reg("R8 ignored after partial", 1'b0, 32'h00F0_0000);
        wr(1'b0, 32'h00F0_0000);
        chk("R9 unlocked", {31'b0, locked}, 32'h0);

        // R10 dropping the freeze control releases the lock
        pulse(32'h0000_0040);
        chk("R8 relocked", {31'b0, locked}, 32'h1);
        wr(1'b1, 32'h0);
        tick();
        chk("R10 released", {31'b0, locked}, 32'h0);
        pulse(32'h0000_0080);
        chk_reg("R10 capture resumes", 1'b0, 32'h0000_00C0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule